// File: doc/BRIEF.md
# Infrared Receive Register and Interrupt Unit

This block is the software-facing side of an infrared receiver. A run-length sampler, built elsewhere, pushes one byte per detected run into a receive FIFO through a valid/data port, and it pulses a packet-end line when the input has gone idle. Software reaches the block through a simple register port: single-cycle write strobes, and read strobes whose data appears one cycle later. It sets the enable, mode, polarity and threshold fields, which drive the sampler directly. It drains the FIFO one byte per read and services a single interrupt line.

The status word combines three sticky flags (overflow, packet end, data available) with the live FIFO fill count. Each flag is cleared by writing a one to its bit. The data-available condition compares the fill count against a trigger level that software sets, which lets software take bytes in batches rather than one interrupt per byte. The FIFO depth is a parameter; 16 and 64 entries are the intended sizes.

Top module: `irRxCtrl`

## Requirements
- R1: After reset, every configuration output, the interrupt output, the fill count and all status flags are zero.
- R2: A write to offset 0x00 sets the global enable from bit 0, the receive enable from bit 1 and the mode from bits 5:4. A write to offset 0x10 sets the polarity-invert output from bit 2. Both registers read back in the same positions.
- R3: A write to offset 0x34 sets the noise threshold from bits 7:2 and the idle threshold from bits 15:8. Both fields drive the output pins and read back in the same positions.
- R4: A read of offset 0x20 returns the oldest byte in bits 7:0 one cycle after the read strobe and removes it, so bytes come out in the order they were pushed.
- R5: A read of offset 0x30 returns the fill count in the field starting at bit 8. The field is clog2(DEPTH)+1 bits wide.
- R6: A push while the FIFO holds DEPTH bytes, with no pop in the same cycle, discards the byte and sets the overflow flag (status bit 0).
- R7: A read of offset 0x20 while the FIFO is empty returns zero and leaves the fill count unchanged.
- R8: A pulse on packetEnd sets the packet-end flag (status bit 1).
- R9: The data-available flag (status bit 4) is set in each cycle in which the fill count is greater than the trigger level. The trigger level is written at offset 0x2C in the field starting at bit 8.
- R10: Writing ones to status bits 0, 1 or 4 clears the matching flags. If a flag's set condition occurs in the same cycle as its clear, the flag stays set.
- R11: The interrupt output is high exactly when some flag is set and its enable bit at offset 0x2C is set. The enable bits are bit 0 for overflow, bit 1 for packet end and bit 4 for data available.
- R12: A push and a pop in the same cycle on a full FIFO are both accepted. No overflow is flagged and the count stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| pushValid | input | 1 | Sampler byte valid |
| pushData | input | 8 | Sampler byte |
| packetEnd | input | 1 | Sampler packet-end pulse |
| irqOut | output | 1 | Combined interrupt |
| globalEn | output | 1 | Global enable |
| rxEn | output | 1 | Receive enable |
| modeSel | output | 2 | Mode select |
| polInvert | output | 1 | Input polarity invert |
| noiseThr | output | 6 | Noise threshold to the sampler |
| idleThr | output | 8 | Idle threshold to the sampler |

## Verification
A corrupted read or write pointer shows up on the first FIFO read after the fault: the byte returned breaks the order the bytes were pushed in. A wrong occupancy count shows up on the next status read, either in the count field or as an overflow or data-available flag that disagrees with the number of bytes pushed. A flag that fails to set or to clear reaches irqOut in the same cycle it becomes visible in the status register, so the interrupt checks catch it without a status read. The directed scenarios fill the FIFO to DEPTH and one past it, read the FIFO while it is empty, push and pop together on a full FIFO, and cross the trigger level in both directions.

// File: rtl/irRxPkg.sv
package irRxPkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_FLAGS = 3;

  localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RXCFG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FIFO   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_INTEN  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 8'h34;

  // flag vector index -> status/enable bit position
  localparam int BIT_OVF   = 0;
  localparam int BIT_PEND  = 1;
  localparam int BIT_AVAIL = 4;
  localparam int CNT_LSB   = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_RXCFG, SEL_FIFO,
    SEL_INTEN, SEL_STAT, SEL_SAMPLE, SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   push;
    logic   pop;
    logic   wrCtl;
    logic   wrRxCfg;
    logic   wrIntEn;
    logic   wrSample;
    rdSel_e rdSel;
  } strobe_t;

  function automatic int flagPos(input int idx);
    case (idx)
      0:       return BIT_OVF;
      1:       return BIT_PEND;
      default: return BIT_AVAIL;
    endcase
  endfunction
endpackage

// File: rtl/irRxControl.sv
module irRxControl
  import irRxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 pushValid,
  input  logic                 packetEnd,
  input  logic                 fifoFull,
  input  logic                 fifoEmpty,
  input  logic [CNT_W-1:0]     fillCount,
  input  logic [PTR_W-1:0]     trigLevel,
  input  logic [NUM_FLAGS-1:0] intEn,
  output strobe_t              strobe,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irqOut
);
  logic                 popReq;
  logic                 clrHit;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagClr;
  logic                 unusedCtl;

  assign unusedCtl = ^wrData;

  always_comb begin
    popReq          = rdEn && (addr == OFS_FIFO);
    strobe.pop      = popReq && !fifoEmpty;
    strobe.push     = pushValid && (!fifoFull || strobe.pop);
    strobe.wrCtl    = wrEn && (addr == OFS_CTL);
    strobe.wrRxCfg  = wrEn && (addr == OFS_RXCFG);
    strobe.wrIntEn  = wrEn && (addr == OFS_INTEN);
    strobe.wrSample = wrEn && (addr == OFS_SAMPLE);
    if (!rdEn) begin
      strobe.rdSel = SEL_NONE;
    end else begin
      case (addr)
        OFS_CTL:    strobe.rdSel = SEL_CTL;
        OFS_RXCFG:  strobe.rdSel = SEL_RXCFG;
        OFS_FIFO:   strobe.rdSel = SEL_FIFO;
        OFS_INTEN:  strobe.rdSel = SEL_INTEN;
        OFS_STAT:   strobe.rdSel = SEL_STAT;
        OFS_SAMPLE: strobe.rdSel = SEL_SAMPLE;
        default:    strobe.rdSel = SEL_ZERO;
      endcase
    end
  end

  assign clrHit     = wrEn && (addr == OFS_STAT);
  assign flagSet[0] = pushValid && fifoFull && !strobe.pop;
  assign flagSet[1] = packetEnd;
  assign flagSet[2] = {1'b0, trigLevel} < fillCount;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    assign flagClr[g] = clrHit && wrData[flagPos(g)];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[g] <= 1'b0;
      else       flags[g] <= flagSet[g] | (flags[g] & ~flagClr[g]);
    end
  end

  assign irqOut = |(flags & intEn);
endmodule

// File: rtl/irRxDatapath.sv
module irRxDatapath
  import irRxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [7:0]           pushData,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 globalEn,
  output logic                 rxEn,
  output logic [1:0]           modeSel,
  output logic                 polInvert,
  output logic [5:0]           noiseThr,
  output logic [7:0]           idleThr,
  output logic [NUM_FLAGS-1:0] intEn,
  output logic [PTR_W-1:0]     trigLevel,
  output logic [CNT_W-1:0]     fillCount,
  output logic                 fifoFull,
  output logic                 fifoEmpty,
  output logic [DATA_W-1:0]    rdData
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] rdNext;
  logic              unusedData;

  assign unusedData = ^wrData;
  assign fifoFull   = (fillCount == FULL_CNT);
  assign fifoEmpty  = (fillCount == '0);

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      rxEn      <= 1'b0;
      modeSel   <= '0;
      polInvert <= 1'b0;
      noiseThr  <= '0;
      idleThr   <= '0;
      intEn     <= '0;
      trigLevel <= '0;
    end else begin
      if (strobe.wrCtl) begin
        globalEn <= wrData[0];
        rxEn     <= wrData[1];
        modeSel  <= wrData[5:4];
      end
      if (strobe.wrRxCfg) polInvert <= wrData[2];
      if (strobe.wrIntEn) begin
        intEn     <= {wrData[BIT_AVAIL], wrData[BIT_PEND], wrData[BIT_OVF]};
        trigLevel <= wrData[CNT_LSB +: PTR_W];
      end
      if (strobe.wrSample) begin
        noiseThr <= wrData[7:2];
        idleThr  <= wrData[15:8];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_CTL: begin
        rdNext[0]   = globalEn;
        rdNext[1]   = rxEn;
        rdNext[5:4] = modeSel;
      end
      SEL_RXCFG: rdNext[2] = polInvert;
      SEL_FIFO:  rdNext[7:0] = fifoEmpty ? 8'h00 : mem[rdPtr];
      SEL_INTEN: begin
        rdNext[BIT_OVF]            = intEn[0];
        rdNext[BIT_PEND]           = intEn[1];
        rdNext[BIT_AVAIL]          = intEn[2];
        rdNext[CNT_LSB +: PTR_W]   = trigLevel;
      end
      SEL_STAT: begin
        rdNext[BIT_OVF]            = flags[0];
        rdNext[BIT_PEND]           = flags[1];
        rdNext[BIT_AVAIL]          = flags[2];
        rdNext[CNT_LSB +: CNT_W]   = fillCount;
      end
      SEL_SAMPLE: begin
        rdNext[7:2]  = noiseThr;
        rdNext[15:8] = idleThr;
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rdData <= '0;
    else if (strobe.rdSel != SEL_NONE)  rdData <= rdNext;
  end
endmodule

// File: rtl/irRxCtrl.sv
module irRxCtrl
  import irRxPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        pushValid,
  input  logic [7:0]  pushData,
  input  logic        packetEnd,
  output logic        irqOut,
  output logic        globalEn,
  output logic        rxEn,
  output logic [1:0]  modeSel,
  output logic        polInvert,
  output logic [5:0]  noiseThr,
  output logic [7:0]  idleThr
);
  strobe_t              strobe;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] intEn;
  logic [PTR_W-1:0]     trigLevel;
  logic [CNT_W-1:0]     fillCount;
  logic                 fifoFull;
  logic                 fifoEmpty;

  irRxControl #(.DEPTH(DEPTH)) i_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .pushValid(pushValid), .packetEnd(packetEnd),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fillCount(fillCount),
    .trigLevel(trigLevel), .intEn(intEn), .strobe(strobe),
    .flags(flags), .irqOut(irqOut)
  );

  irRxDatapath #(.DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pushData(pushData), .flags(flags), .globalEn(globalEn),
    .rxEn(rxEn), .modeSel(modeSel), .polInvert(polInvert),
    .noiseThr(noiseThr), .idleThr(idleThr), .intEn(intEn),
    .trigLevel(trigLevel), .fillCount(fillCount), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .rdData(rdData)
  );
endmodule

// File: rtl/irRxCtrlChk.sv
module irRxCtrlChk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [7:0]       addr,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic             pushValid,
  input logic             packetEnd,
  input logic             irqOut,
  input logic [CNT_W-1:0] fillCount,
  input logic [2:0]       flags
);
  // R6, R12: occupancy never passes the depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  p_overflow_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && fillCount == CNT_W'(DEPTH) && !(rdEn && addr == 8'h20))
      |=> flags[0]);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h20 && fillCount == '0 && !pushValid)
      |=> (rdData == 32'h0 && fillCount == '0));

  p_packet_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |=> flags[1]);

  p_clear_pend_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h30 && wrData[1] && !packetEnd) |=> !flags[1]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flags == 3'b000) |-> !irqOut);
endmodule

bind irRxCtrl irRxCtrlChk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .pushValid(pushValid),
  .packetEnd(packetEnd), .irqOut(irqOut), .fillCount(fillCount),
  .flags(flags)
);

// File: tb/test_irRxCtrl.sv
module test_irRxCtrl;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pushValid = 1'b0;
  logic [7:0]  pushData = '0;
  logic        packetEnd = 1'b0;
  logic        irqOut, globalEn, rxEn, polInvert;
  logic [1:0]  modeSel;
  logic [5:0]  noiseThr;
  logic [7:0]  idleThr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irRxCtrl #(.DEPTH(DEPTH)) i_irRxCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pushValid(pushValid),
    .pushData(pushData), .packetEnd(packetEnd), .irqOut(irqOut),
    .globalEn(globalEn), .rxEn(rxEn), .modeSel(modeSel),
    .polInvert(polInvert), .noiseThr(noiseThr), .idleThr(idleThr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); pushData = b; pushValid = 1'b1;
    @(negedge clk); pushValid = 1'b0;
  endtask

  function automatic logic [31:0] cntOf(input logic [31:0] s);
    return (s >> 8) & ((32'd1 << CNT_W) - 1);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check({globalEn, rxEn, modeSel, polInvert, noiseThr, idleThr, irqOut} == '0,
          "R1 outputs", {globalEn, rxEn, modeSel, polInvert}, 0);
    regRead(8'h30, d);
    check(d == 32'h0, "R1 status", d, 0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    regWrite(8'h00, 32'h33);
    check(globalEn && rxEn && modeSel == 2'b11, "R2 ctl pins",
          {globalEn, rxEn, modeSel}, 4'hF);
    regRead(8'h00, d);
    check(d == 32'h33, "R2 ctl readback", d, 32'h33);
    regWrite(8'h10, 32'h4);
    check(polInvert == 1'b1, "R2 polarity pin", polInvert, 1);
    regRead(8'h10, d);
    check(d == 32'h4, "R2 rxcfg readback", d, 32'h4);
    regWrite(8'h34, 32'hA554);
    check(noiseThr == 6'h15 && idleThr == 8'hA5, "R3 threshold pins",
          {noiseThr, idleThr}, {6'h15, 8'hA5});
    regRead(8'h34, d);
    check(d == 32'hA554, "R3 sample readback", d, 32'hA554);
  endtask

  task automatic t_order();
    logic [31:0] d;
    logic [7:0] pat [3] = '{8'h11, 8'h82, 8'hFF};
    regWrite(8'h2C, 32'h0F00);
    regWrite(8'h30, 32'hFF);
    for (int i = 0; i < 3; i++) pushByte(pat[i]);
    regRead(8'h30, d);
    check(cntOf(d) == 3, "R5 count after 3 pushes", cntOf(d), 3);
    for (int i = 0; i < 3; i++) begin
      regRead(8'h20, d);
      check(d == {24'h0, pat[i]}, "R4 fifo order", d, pat[i]);
    end
  endtask

  task automatic t_empty();
    logic [31:0] d;
    regRead(8'h20, d);
    check(d == 32'h0, "R7 empty read data", d, 0);
    regRead(8'h30, d);
    check(cntOf(d) == 0, "R7 count after empty read", cntOf(d), 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    regWrite(8'h30, 32'hFF);
    for (int i = 0; i <= DEPTH; i++) pushByte(8'h40 + 8'(i));
    regRead(8'h30, d);
    check(d[0] == 1'b1, "R6 overflow flag", d[0], 1);
    check(cntOf(d) == DEPTH, "R6 count at depth", cntOf(d), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      regRead(8'h20, d);
      check(d == 32'h40 + i, "R6 kept bytes", d, 32'h40 + i);
    end
    regRead(8'h30, d);
    check(cntOf(d) == 0, "R6 drained", cntOf(d), 0);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) pushByte(8'h60 + 8'(i));
    regWrite(8'h30, 32'hFF);
    @(negedge clk); pushData = 8'hEE; pushValid = 1'b1; addr = 8'h20; rdEn = 1'b1;
    @(negedge clk); pushValid = 1'b0; rdEn = 1'b0;
    check(rdData == 32'h60, "R12 head on push+pop", rdData, 32'h60);
    regRead(8'h30, d);
    check(d[0] == 1'b0, "R12 no overflow", d[0], 0);
    check(cntOf(d) == DEPTH, "R12 count stays", cntOf(d), DEPTH);
    for (int i = 1; i < DEPTH; i++) begin
      regRead(8'h20, d);
      check(d == 32'h60 + i, "R12 drain order", d, 32'h60 + i);
    end
    regRead(8'h20, d);
    check(d == 32'hEE, "R12 new byte last", d, 32'hEE);
  endtask

  task automatic t_pendClear();
    logic [31:0] d;
    regWrite(8'h30, 32'hFF);
    @(negedge clk); packetEnd = 1'b1;
    @(negedge clk); packetEnd = 1'b0;
    regRead(8'h30, d);
    check(d[1] == 1'b1, "R8 packet-end flag", d[1], 1);
    regWrite(8'h30, 32'h02);
    regRead(8'h30, d);
    check(d[1] == 1'b0, "R10 w1c clears", d[1], 0);
    @(negedge clk); addr = 8'h30; wrData = 32'h02; wrEn = 1'b1; packetEnd = 1'b1;
    @(negedge clk); wrEn = 1'b0; packetEnd = 1'b0;
    regRead(8'h30, d);
    check(d[1] == 1'b1, "R10 set beats clear", d[1], 1);
    regWrite(8'h30, 32'hFF);
  endtask

  task automatic t_avail();
    logic [31:0] d;
    regWrite(8'h2C, 32'h0210);
    regWrite(8'h30, 32'hFF);
    pushByte(8'hA1); pushByte(8'hA2);
    regRead(8'h30, d);
    check(d[4] == 1'b0, "R9 at level no flag", d[4], 0);
    check(irqOut == 1'b0, "R11 irq low at level", irqOut, 0);
    pushByte(8'hA3);
    @(negedge clk);
    regRead(8'h30, d);
    check(d[4] == 1'b1, "R9 above level flag", d[4], 1);
    check(irqOut == 1'b1, "R11 irq from avail", irqOut, 1);
    for (int i = 0; i < 3; i++) regRead(8'h20, d);
    regWrite(8'h30, 32'h10);
    check(irqOut == 1'b0, "R10 avail cleared irq", irqOut, 0);
  endtask

  task automatic t_irqMask();
    regWrite(8'h2C, 32'h0F01);
    regWrite(8'h30, 32'hFF);
    @(negedge clk); packetEnd = 1'b1;
    @(negedge clk); packetEnd = 1'b0;
    check(irqOut == 1'b0, "R11 masked packet-end", irqOut, 0);
    regWrite(8'h2C, 32'h0F02);
    check(irqOut == 1'b1, "R11 enabled packet-end", irqOut, 1);
    regWrite(8'h30, 32'hFF);
    check(irqOut == 1'b0, "R11 cleared", irqOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_config();
    t_order();
    t_empty();
    t_overflow();
    t_simul();
    t_pendClear();
    t_avail();
    t_irqMask();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule